// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block keeps a running tally of DRAM refreshes that are owed and raises refresh requests toward a memory scheduler. A periodic tick input adds one owed refresh to the tally. Each refresh the scheduler accepts removes one. When the tally climbs above a selectable watermark, a panic flag is raised next to the normal request, so the scheduler can move refresh ahead of ordinary traffic.

Two enables set how the tally behaves. It can be frozen, it can accumulate while no requests go out, or it can run with requests issued. Ranks are refreshed either as one group or one at a time in a round-robin order, and a one-hot rank target tells the scheduler which ranks the next refresh covers. An impedance-calibration (rcomp) request is granted through a gate. In one-rank-at-a-time mode, that gate first waits a number of ticks set by configuration. The gate never grants while a panic is pending.

Top module: `drf_req_ctrl`

## Requirements
- R1: After synchronous reset the owed count is 0, ref_req_o, panic_o and rc_grant_o are 0, and the round-robin rank pointer selects rank 0 (rank_tgt_o = 4'b0001 when indep_rank_i = 1).
- R2: A tick adds one owed refresh when counting is on. An accepted grant removes one. A tick and an accepted grant in the same cycle leave the count unchanged. The count saturates at 15 and never wraps.
- R3: With ref_en_i = 0 and cnt_keep_i = 0 the count is frozen. With ref_en_i = 0 and cnt_keep_i = 1 the count accumulates but no request is raised. With ref_en_i = 1 the count always runs, whatever cnt_keep_i is.
- R4: ref_req_o is 1 exactly when init_done_i = 1, ref_en_i = 1 and the owed count is nonzero.
- R5: panic_o is 1 exactly when ref_req_o is 1 and the owed count is strictly greater than the watermark chosen by panic_sel_i (00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8). It drops as soon as the count is at or below that level.
- R6: With indep_rank_i = 0, rank_tgt_o = 4'b1111. With indep_rank_i = 1, rank_tgt_o is one-hot (bit n selects rank n) and moves to the next rank, wrapping from 3 to 0, on each accepted grant.
- R7: With indep_rank_i = 1, rc_grant_o waits until rc_wait_i plus the selected quiet count have elapsed in ticks, counted while rc_req_i is held. The quiet count is rc_quiet_dir_i when rc_direct_i = 1 and rc_quiet_ind_i otherwise.
- R8: With indep_rank_i = 0, a held rc_req_i is granted at once, with no tick wait.
- R9: rc_grant_o is 0 while panic_o is 1. A grant lasts one cycle and restarts the tick wait.
- R10: grant_i has no effect on the count or the rank pointer while ref_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic refresh interval pulse |
| grant_i | input | 1 | Scheduler accepted a refresh this cycle |
| init_done_i | input | 1 | DRAM initialisation complete |
| ref_en_i | input | 1 | Refresh issuing enabled |
| cnt_keep_i | input | 1 | Keep counting while refresh is disabled |
| indep_rank_i | input | 1 | 1 = one rank at a time, 0 = all ranks together |
| panic_sel_i | input | 2 | Watermark select |
| rc_req_i | input | 1 | Rcomp service request (level) |
| rc_direct_i | input | 1 | Use the direct quiet count |
| rc_wait_i | input | 5 | Rcomp wait in ticks |
| rc_quiet_dir_i | input | 5 | Direct quiet count in ticks |
| rc_quiet_ind_i | input | 5 | Indirect quiet count in ticks |
| ref_req_o | output | 1 | Refresh request |
| panic_o | output | 1 | Panic refresh flag |
| rank_tgt_o | output | 4 | One-hot rank target |
| rc_grant_o | output | 1 | Rcomp grant pulse |

## Verification
The bench drives the count past every watermark setting and then drains it one grant at a time. A wrong threshold or an off-by-one compare would move the panic edge by a cycle. It fills the count past 15 and mixes ticks with grants in the same cycle. A design that wraps, or that counts both events, would later raise or drop requests at the wrong time. Grants are sent while no request is up, which would move the rank pointer or underflow the count. The rcomp gate is tested with short direct and indirect windows, with panic pending, and in all-rank mode. An early grant, a missing grant or a grant held for two cycles shows up on rc_grant_o.

// File: rtl/drf_pkg.sv
package drf_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_ACCUM  = 2'd1,
        MODE_ACTIVE = 2'd2
    } drf_mode_e;

    typedef struct packed {
        logic req;
        logic panic;
    } drf_req_t;

    localparam int unsigned PANIC_BASE = 5;

    function automatic drf_mode_e decode_mode(input logic en, input logic keep);
        if (en)
            return MODE_ACTIVE;
        else if (keep)
            return MODE_ACCUM;
        return MODE_IDLE;
    endfunction

    function automatic int unsigned panic_level(input logic [1:0] sel);
        return PANIC_BASE + int'(sel);
    endfunction

endpackage

// File: rtl/drf_owed_ctr.sv
module drf_owed_ctr #(
    parameter int OWE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [OWE_W-1:0] owed
);
    localparam logic [OWE_W-1:0] OWE_MAX = {OWE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            case ({inc, dec})
                2'b10: if (owed != OWE_MAX) owed <= owed + 1'b1;
                2'b01: if (owed != '0)      owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/drf_rank_sel.sv
module drf_rank_sel #(
    parameter int RANKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             indep,
    input  logic             advance,
    output logic [RANKS-1:0] tgt
);
    localparam int PTR_W = (RANKS > 1) ? $clog2(RANKS) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RANKS - 1);

    logic [PTR_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance && indep)
            ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        assign tgt[r] = indep ? (ptr == PTR_W'(r)) : 1'b1;
    end
endmodule

// File: rtl/drf_rcomp_gate.sv
module drf_rcomp_gate #(
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic              indep,
    input  logic              direct,
    input  logic              block,
    input  logic [TICK_W-1:0] wait_cnt,
    input  logic [TICK_W-1:0] quiet_dir,
    input  logic [TICK_W-1:0] quiet_ind,
    output logic              grant,
    output logic [TICK_W:0]   elapsed
);
    localparam int WC_W = TICK_W + 1;
    localparam logic [WC_W-1:0] WC_MAX = {WC_W{1'b1}};

    logic [WC_W-1:0] need;
    logic [TICK_W-1:0] quiet;

    always_comb begin
        quiet = direct ? quiet_dir : quiet_ind;
        need  = indep ? ({1'b0, wait_cnt} + {1'b0, quiet}) : '0;
        grant = req && !block && (elapsed >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || !req || grant)
            elapsed <= '0;
        else if (tick && elapsed != WC_MAX)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/drf_req_ctrl.sv
module drf_req_ctrl #(
    parameter int OWE_W  = 4,
    parameter int RANKS  = 4,
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              grant_i,
    input  logic              init_done_i,
    input  logic              ref_en_i,
    input  logic              cnt_keep_i,
    input  logic              indep_rank_i,
    input  logic [1:0]        panic_sel_i,
    input  logic              rc_req_i,
    input  logic              rc_direct_i,
    input  logic [TICK_W-1:0] rc_wait_i,
    input  logic [TICK_W-1:0] rc_quiet_dir_i,
    input  logic [TICK_W-1:0] rc_quiet_ind_i,
    output logic              ref_req_o,
    output logic              panic_o,
    output logic [RANKS-1:0]  rank_tgt_o,
    output logic              rc_grant_o
);
    import drf_pkg::*;

    drf_mode_e         mode;
    drf_req_t          rq;
    logic [OWE_W-1:0]  owed_q;
    logic [TICK_W:0]   rc_elapsed;
    logic              count_on;
    logic              take;

    always_comb begin
        mode      = decode_mode(ref_en_i, cnt_keep_i);
        count_on  = (mode != MODE_IDLE);
        rq.req    = init_done_i && (mode == MODE_ACTIVE) && (owed_q != '0);
        rq.panic  = rq.req && (owed_q > OWE_W'(panic_level(panic_sel_i)));
        take      = grant_i && rq.req;
        ref_req_o = rq.req;
        panic_o   = rq.panic;
    end

    drf_owed_ctr #(.OWE_W(OWE_W)) u_owed (
        .clk  (clk),
        .rst  (rst),
        .inc  (tick_i && count_on),
        .dec  (take),
        .owed (owed_q)
    );

    drf_rank_sel #(.RANKS(RANKS)) u_rank (
        .clk     (clk),
        .rst     (rst),
        .indep   (indep_rank_i),
        .advance (take),
        .tgt     (rank_tgt_o)
    );

    drf_rcomp_gate #(.TICK_W(TICK_W)) u_rc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_i),
        .req       (rc_req_i),
        .indep     (indep_rank_i),
        .direct    (rc_direct_i),
        .block     (rq.panic),
        .wait_cnt  (rc_wait_i),
        .quiet_dir (rc_quiet_dir_i),
        .quiet_ind (rc_quiet_ind_i),
        .grant     (rc_grant_o),
        .elapsed   (rc_elapsed)
    );
endmodule

// File: rtl/drf_req_ctrl_chk.sv
module drf_req_ctrl_chk #(
    parameter int OWE_W  = 4,
    parameter int RANKS  = 4,
    parameter int TICK_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              init_done_i,
    input logic              ref_en_i,
    input logic              indep_rank_i,
    input logic              ref_req_o,
    input logic              panic_o,
    input logic [RANKS-1:0]  rank_tgt_o,
    input logic              rc_grant_o,
    input logic [OWE_W-1:0]  owed_q,
    input logic [TICK_W:0]   rc_elapsed
);
    // R2
    owed_step_chk: assert property (@(posedge clk) disable iff (rst)
        (owed_q == $past(owed_q)) || (owed_q == $past(owed_q) + 1'b1) || (owed_q == $past(owed_q) - 1'b1));

    // R4
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req_o |-> (init_done_i && ref_en_i));

    // R5
    panic_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
        panic_o |-> ref_req_o);

    // R6
    rank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        indep_rank_i |-> $onehot(rank_tgt_o));

    // R6
    rank_all_chk: assert property (@(posedge clk) disable iff (rst)
        !indep_rank_i |-> (rank_tgt_o == {RANKS{1'b1}}));

    // R9
    rc_block_chk: assert property (@(posedge clk) disable iff (rst)
        rc_grant_o |-> !panic_o);

    // R9
    rc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        rc_grant_o |=> (rc_elapsed == '0));
endmodule

bind drf_req_ctrl drf_req_ctrl_chk #(.OWE_W(OWE_W), .RANKS(RANKS), .TICK_W(TICK_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .init_done_i  (init_done_i),
    .ref_en_i     (ref_en_i),
    .indep_rank_i (indep_rank_i),
    .ref_req_o    (ref_req_o),
    .panic_o      (panic_o),
    .rank_tgt_o   (rank_tgt_o),
    .rc_grant_o   (rc_grant_o),
    .owed_q       (owed_q),
    .rc_elapsed   (rc_elapsed)
);

// File: tb/test_drf_req_ctrl.sv
module test_drf_req_ctrl;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 0, grant_i = 0, init_done_i = 0, ref_en_i = 0, cnt_keep_i = 0;
    logic       indep_rank_i = 1'b1, rc_req_i = 0, rc_direct_i = 0;
    logic [1:0] panic_sel_i = 2'b00;
    logic [4:0] rc_wait_i = 5'd6, rc_quiet_dir_i = 5'd16, rc_quiet_ind_i = 5'd24;
    logic       ref_req_o, panic_o, rc_grant_o;
    logic [3:0] rank_tgt_o;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // reference state
    int m_cnt = 0, m_ptr = 0, m_wc = 0;

    always #(CLK_P/2) clk = ~clk;

    drf_req_ctrl i_drf_req_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick_i), .grant_i(grant_i),
        .init_done_i(init_done_i), .ref_en_i(ref_en_i), .cnt_keep_i(cnt_keep_i),
        .indep_rank_i(indep_rank_i), .panic_sel_i(panic_sel_i), .rc_req_i(rc_req_i),
        .rc_direct_i(rc_direct_i), .rc_wait_i(rc_wait_i), .rc_quiet_dir_i(rc_quiet_dir_i),
        .rc_quiet_ind_i(rc_quiet_ind_i), .ref_req_o(ref_req_o), .panic_o(panic_o),
        .rank_tgt_o(rank_tgt_o), .rc_grant_o(rc_grant_o)
    );

    function automatic bit e_req();
        return init_done_i && ref_en_i && (m_cnt != 0);
    endfunction
    function automatic bit e_panic();
        return e_req() && (m_cnt > 5 + int'(panic_sel_i));
    endfunction
    function automatic logic [3:0] e_rank();
        return indep_rank_i ? 4'(1 << m_ptr) : 4'b1111;
    endfunction
    function automatic bit e_rc();
        int need;
        need = indep_rank_i ? int'(rc_wait_i) + int'(rc_direct_i ? rc_quiet_dir_i : rc_quiet_ind_i) : 0;
        return rc_req_i && !e_panic() && (m_wc >= need);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
        end
    endtask

    // reference update on the clock edge
    always @(posedge clk) begin
        bit take, inc, rg;
        if (rst) begin
            m_cnt = 0; m_ptr = 0; m_wc = 0;
        end else begin
            take = grant_i && e_req();
            inc  = tick_i && (ref_en_i || cnt_keep_i);
            rg   = e_rc();
            if (inc && !take) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
            else if (take && !inc) m_cnt = m_cnt - 1;
            if (take && indep_rank_i) m_ptr = (m_ptr + 1) % 4;
            if (!rc_req_i || rg) m_wc = 0;
            else if (tick_i) m_wc = (m_wc < 63) ? m_wc + 1 : 63;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R4 ref_req", int'(ref_req_o), int'(e_req()));
            check("R5 panic", int'(panic_o), int'(e_panic()));
            check("R6 rank_tgt", int'(rank_tgt_o), int'(e_rank()));
            check("R7 R8 R9 rc_grant", int'(rc_grant_o), int'(e_rc()));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; step(1); tick_i = 1'b0; step(gap);
        end
    endtask

    task automatic grants(input int n);
        for (int i = 0; i < n; i++) begin
            grant_i = 1'b1; step(1); grant_i = 1'b0; step(1);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        #1;
        check("R1 ref_req", int'(ref_req_o), 0);
        check("R1 panic", int'(panic_o), 0);
        check("R1 rank_tgt", int'(rank_tgt_o), 1);
        check("R1 rc_grant", int'(rc_grant_o), 0);

        // R3 idle mode: counter frozen, later enabling shows nothing owed
        phase = "R3"; init_done_i = 1'b1;
        step(1);
        ticks(5, 1);
        ref_en_i = 1'b1; step(2);
        ref_en_i = 1'b0; cnt_keep_i = 1'b1;
        ticks(7, 1);               // R3 accumulate without request
        ref_en_i = 1'b1; step(2);  // 7 owed: request and panic (>5)
        cnt_keep_i = 1'b0;

        // R5 sweep watermark selects while draining
        phase = "R5";
        for (int s = 0; s < 4; s++) begin
            panic_sel_i = 2'(s); step(1);
        end
        panic_sel_i = 2'b00;
        grants(3);

        // R2 saturation and simultaneous tick plus grant
        phase = "R2";
        ticks(20, 0);
        panic_sel_i = 2'b11; step(1);
        tick_i = 1'b1; grant_i = 1'b1; step(3);
        tick_i = 1'b0;
        grants(10);
        panic_sel_i = 2'b01;
        grants(4);

        // R4 init_done gating
        phase = "R4";
        ticks(2, 0);
        init_done_i = 1'b0; step(2);
        grants(2);
        init_done_i = 1'b1;

        // R6 round robin, R10 grant while no request
        phase = "R6";
        ticks(6, 0);
        grants(8);
        phase = "R10";
        grants(4);
        ref_en_i = 1'b0; cnt_keep_i = 1'b1; ticks(2, 0);
        grants(3);
        ref_en_i = 1'b1; grants(2);
        indep_rank_i = 1'b0; ticks(2, 0); grants(2); indep_rank_i = 1'b1;

        // R7 rcomp wait windows
        phase = "R7";
        rc_wait_i = 5'd2; rc_quiet_dir_i = 5'd1; rc_quiet_ind_i = 5'd3;
        rc_direct_i = 1'b1; rc_req_i = 1'b1;
        ticks(8, 2);
        rc_direct_i = 1'b0;
        ticks(12, 1);
        rc_req_i = 1'b0; step(2);

        // R8 all-rank immediate grant
        phase = "R8";
        indep_rank_i = 1'b0; rc_req_i = 1'b1; step(4);
        rc_req_i = 1'b0; indep_rank_i = 1'b1; step(1);

        // R9 blocked while panic
        phase = "R9";
        panic_sel_i = 2'b00;
        ticks(8, 0);
        indep_rank_i = 1'b0; rc_req_i = 1'b1; step(3);
        grants(4);
        rc_req_i = 1'b0; step(1);
        indep_rank_i = 1'b1; rc_wait_i = 5'd0; rc_quiet_ind_i = 5'd0;
        rc_req_i = 1'b1; step(3); rc_req_i = 1'b0;

        // mixed random traffic
        phase = "R2 R5 R6 R7";
        rc_wait_i = 5'd1; rc_quiet_dir_i = 5'd2; rc_quiet_ind_i = 5'd1;
        for (int i = 0; i < 400; i++) begin
            tick_i       = ($urandom_range(0, 2) == 0);
            grant_i      = ($urandom_range(0, 3) == 0);
            ref_en_i     = ($urandom_range(0, 7) != 0);
            cnt_keep_i   = 1'($urandom_range(0, 1));
            indep_rank_i = ($urandom_range(0, 5) != 0);
            panic_sel_i  = 2'($urandom_range(0, 3));
            rc_req_i     = ($urandom_range(0, 3) != 0);
            rc_direct_i  = 1'($urandom_range(0, 1));
            step(1);
        end
        tick_i = 0; grant_i = 0; rc_req_i = 0;
        step(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule